// File: doc/BRIEF.md
# Debug Halt Entry and Exit Controller

This block decides when a small processor core is held in its debug state and drives the side effects of that state. The core enters debug when it reports that a breakpoint instruction has executed, or when the active-low debug pin is low on the last cycle of system reset. The core leaves debug when software writes 0 to the mode bit, or when a power-on, brownout or watchdog reset cause is signalled.

While the core is in debug, instruction fetch is off so the core idles. A debugger execute request turns fetch on for one instruction. The watchdog is refreshed on every cycle while it is enabled. If the core was in halt mode when debug began, the block asks the core to leave halt. Debug never gates the clock or the peripherals; only stop mode gates them.

Top module: `dbg_mode_ctl`

## Requirements
- R1: A cycle with `brkStrobe` high and no exit condition sets `dbgMode` to 1 from the next clock edge.
- R2: `dbgPinN` passes through a two-stage synchronizer. The pin is held stable through the final reset cycles. If it is low on the last cycle with `sysRst` high, `dbgMode` is 1 after the first clock edge on which `sysRst` is low. If it is high, `dbgMode` does not change.
- R3: A write with `ctlWrEn`=1 and `ctlWrData`=0 clears `dbgMode` at the next edge. This clear wins over a breakpoint in the same cycle.
- R4: `porStrobe`, `borStrobe` or `wdtStrobe` high clears `dbgMode` at the next edge. This clear wins over a breakpoint in the same cycle.
- R5: `fetchEn` is 1 whenever `dbgMode` is 0. `fetchEn` is 0 while `dbgMode` is 1 and no execute request is in progress.
- R6: `wdtRefresh` equals `dbgMode` AND `wdtEnable` on every cycle.
- R7: `haltExitReq` is a one-cycle pulse. It is high in exactly the first cycle of debug, and only when `haltMode` was 1 in the cycle in which entry was decided.
- R8: `periphEn` equals NOT `stopMode`, whatever the value of `dbgMode`.
- R9: `dbgMode` is the mode bit as software reads it back. A write of 1 while outside debug does not set it.
- R10: In debug, an `execReq` turns `fetchEn` on from the next cycle. Fetch stays on up to and including the cycle that carries `instrDone`, and is 0 from the next cycle. Further requests are ignored while one is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the block's own registers |
| sysRst | input | 1 | System reset level, high while the chip is held in reset |
| dbgPinN | input | 1 | Debug pin, active low, asynchronous |
| brkStrobe | input | 1 | Breakpoint instruction executed |
| porStrobe | input | 1 | Power-on reset cause |
| borStrobe | input | 1 | Brownout reset cause |
| wdtStrobe | input | 1 | Watchdog reset cause |
| ctlWrEn | input | 1 | Debug control register write enable |
| ctlWrData | input | 1 | Mode bit value being written |
| stopMode | input | 1 | Core is in stop mode |
| haltMode | input | 1 | Core is in halt mode |
| wdtEnable | input | 1 | Watchdog is enabled |
| execReq | input | 1 | Debugger requests execution of one instruction |
| instrDone | input | 1 | Core completed an instruction |
| fetchEn | output | 1 | Instruction fetch enable |
| haltExitReq | output | 1 | Request to leave halt mode |
| wdtRefresh | output | 1 | Watchdog refresh |
| dbgMode | output | 1 | Debug state, read back as the mode bit |
| periphEn | output | 1 | Clock and peripheral run enable |

## Verification
Properties check on every cycle the next-edge effects of breakpoints, software clears and reset causes, including their priority. They also check that fetch is off on the first cycle of debug, that fetch ends after an instruction completes, that the watchdog refresh follows the enable, and that the halt-exit pulse lines up with the rise of the mode bit. Entry from the pin at the end of reset depends on a long stretch of reset and on the synchronizer delay. That entry, the ignored write of 1, and the stop-mode gating are shown only by the bench's directed scenarios. A long random run then compares every output against a cycle model.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
  // Strobes from the control decoder to the state registers
  typedef struct packed {
    logic setMode;
    logic clrMode;
    logic startExec;
    logic endExec;
    logic haltExit;
  } dbgStrobe_t;
endpackage

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sysRst,
  input  logic       dbgPinN,
  input  logic       brkStrobe,
  input  logic       porStrobe,
  input  logic       borStrobe,
  input  logic       wdtStrobe,
  input  logic       ctlWrEn,
  input  logic       ctlWrData,
  input  logic       haltMode,
  input  logic       execReq,
  input  logic       instrDone,
  input  logic       dbgMode,
  input  logic       execActive,
  output dbgStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          pinLowLast;
  logic          sysRstQ;
  logic          causeExit, swClear, pinEntry, entryReq, clearReq;

  // Synchronizer chain, idle level is high (pin inactive)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[LAST-1:0], dbgPinN};
  end

  // Remember the pin level of every reset cycle; the last one survives
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLowLast <= 1'b0;
      sysRstQ    <= 1'b0;
    end else begin
      sysRstQ <= sysRst;
      if (sysRst) pinLowLast <= ~syncQ[LAST];
    end
  end

  always_comb begin
    causeExit = porStrobe | borStrobe | wdtStrobe;
    swClear   = ctlWrEn & ~ctlWrData;
    pinEntry  = sysRstQ & ~sysRst & pinLowLast;
    entryReq  = brkStrobe | pinEntry;
    clearReq  = causeExit | swClear;

    strobe.clrMode   = clearReq;
    strobe.setMode   = entryReq & ~clearReq & ~dbgMode;
    strobe.haltExit  = entryReq & ~clearReq & ~dbgMode & haltMode;
    strobe.startExec = dbgMode & ~execActive & execReq & ~clearReq;
    strobe.endExec   = execActive & (instrDone | clearReq);
  end
endmodule

// File: rtl/dbg_mode_state.sv
module dbg_mode_state
  import dbg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dbgStrobe_t strobe,
  input  logic       stopMode,
  input  logic       wdtEnable,
  output logic       dbgMode,
  output logic       execActive,
  output logic       haltExitReq,
  output logic       fetchEn,
  output logic       wdtRefresh,
  output logic       periphEn
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgMode     <= 1'b0;
      execActive  <= 1'b0;
      haltExitReq <= 1'b0;
    end else begin
      if (strobe.clrMode)      dbgMode <= 1'b0;
      else if (strobe.setMode) dbgMode <= 1'b1;

      if (strobe.endExec)        execActive <= 1'b0;
      else if (strobe.startExec) execActive <= 1'b1;

      haltExitReq <= strobe.haltExit;
    end
  end

  assign fetchEn    = ~dbgMode | execActive;
  assign wdtRefresh = dbgMode & wdtEnable;
  assign periphEn   = ~stopMode;
endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl
  import dbg_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sysRst,
  input  logic dbgPinN,
  input  logic brkStrobe,
  input  logic porStrobe,
  input  logic borStrobe,
  input  logic wdtStrobe,
  input  logic ctlWrEn,
  input  logic ctlWrData,
  input  logic stopMode,
  input  logic haltMode,
  input  logic wdtEnable,
  input  logic execReq,
  input  logic instrDone,
  output logic fetchEn,
  output logic haltExitReq,
  output logic wdtRefresh,
  output logic dbgMode,
  output logic periphEn
);
  dbgStrobe_t strobe;
  logic       execActive;

  dbg_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .dbgPinN(dbgPinN),
    .brkStrobe(brkStrobe), .porStrobe(porStrobe), .borStrobe(borStrobe),
    .wdtStrobe(wdtStrobe), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .haltMode(haltMode), .execReq(execReq), .instrDone(instrDone),
    .dbgMode(dbgMode), .execActive(execActive), .strobe(strobe)
  );

  dbg_mode_state uState (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stopMode(stopMode),
    .wdtEnable(wdtEnable), .dbgMode(dbgMode), .execActive(execActive),
    .haltExitReq(haltExitReq), .fetchEn(fetchEn), .wdtRefresh(wdtRefresh),
    .periphEn(periphEn)
  );
endmodule

// File: rtl/dbg_mode_chk.sv
module dbg_mode_chk (
  input logic clk,
  input logic rstN,
  input logic brkStrobe,
  input logic porStrobe,
  input logic borStrobe,
  input logic wdtStrobe,
  input logic ctlWrEn,
  input logic ctlWrData,
  input logic haltMode,
  input logic wdtEnable,
  input logic instrDone,
  input logic dbgMode,
  input logic fetchEn,
  input logic haltExitReq,
  input logic wdtRefresh
);
  logic anyCause, swClr;
  assign anyCause = porStrobe | borStrobe | wdtStrobe;
  assign swClr    = ctlWrEn & ~ctlWrData;

  AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    brkStrobe && !anyCause && !swClr |=> dbgMode); // R1
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    swClr |=> !dbgMode); // R3
  AST_CAUSE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    anyCause |=> !dbgMode); // R4
  AST_FETCH_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !dbgMode |-> fetchEn); // R5
  AST_FETCH_IDLE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dbgMode) |-> !fetchEn); // R5
  AST_WDT_REFRESH: assert property (@(posedge clk) disable iff (!rstN)
    wdtRefresh == (dbgMode && wdtEnable)); // R6
  AST_HALT_EXIT_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    haltExitReq |-> $rose(dbgMode)); // R7
  AST_HALT_EXIT_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !dbgMode && brkStrobe && haltMode && !anyCause && !swClr |=> haltExitReq); // R7
  AST_EXEC_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    dbgMode && fetchEn && instrDone |=> !(dbgMode && fetchEn)); // R10
endmodule

bind dbg_mode_ctl dbg_mode_chk uChk (
  .clk(clk), .rstN(rstN), .brkStrobe(brkStrobe), .porStrobe(porStrobe),
  .borStrobe(borStrobe), .wdtStrobe(wdtStrobe), .ctlWrEn(ctlWrEn),
  .ctlWrData(ctlWrData), .haltMode(haltMode), .wdtEnable(wdtEnable),
  .instrDone(instrDone), .dbgMode(dbgMode), .fetchEn(fetchEn),
  .haltExitReq(haltExitReq), .wdtRefresh(wdtRefresh)
);

// File: tb/tb_dbg_mode_ctl.sv
`timescale 1ns/1ps
module tb_dbg_mode_ctl;
  logic clk = 1'b0;
  logic rstN, sysRst, dbgPinN, brkStrobe, porStrobe, borStrobe, wdtStrobe;
  logic ctlWrEn, ctlWrData, stopMode, haltMode, wdtEnable, execReq, instrDone;
  logic fetchEn, haltExitReq, wdtRefresh, dbgMode, periphEn;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  dbg_mode_ctl dut (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .dbgPinN(dbgPinN),
    .brkStrobe(brkStrobe), .porStrobe(porStrobe), .borStrobe(borStrobe),
    .wdtStrobe(wdtStrobe), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .stopMode(stopMode), .haltMode(haltMode), .wdtEnable(wdtEnable),
    .execReq(execReq), .instrDone(instrDone), .fetchEn(fetchEn),
    .haltExitReq(haltExitReq), .wdtRefresh(wdtRefresh), .dbgMode(dbgMode),
    .periphEn(periphEn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idleInputs();
    brkStrobe = 0; porStrobe = 0; borStrobe = 0; wdtStrobe = 0;
    ctlWrEn = 0; ctlWrData = 0; execReq = 0; instrDone = 0;
  endtask

  // Reference next-state for the random phase
  function automatic logic expMode(input logic m, input logic cause, input logic clr, input logic brk);
    if (cause || clr) return 1'b0;
    if (brk) return 1'b1;
    return m;
  endfunction

  function automatic logic expExec(input logic m, input logic mN, input logic ex,
                                   input logic req, input logic done);
    if (!mN || !m) return 1'b0;
    if (ex) return !done;
    return req;
  endfunction

  initial begin
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic mQ, exQ, hxQ, mN, exN, cause, clr;
    int unused;
    unused = $urandom(32'd4242);
    rstN = 0; sysRst = 1; dbgPinN = 0; stopMode = 0; haltMode = 1; wdtEnable = 0;
    idleInputs();
    #1;
    // Reset state
    check("R5 reset fetchEn", fetchEn, 1'b1);
    check("R1 reset dbgMode", dbgMode, 1'b0);
    check("R7 reset haltExitReq", haltExitReq, 1'b0);
    check("R6 reset wdtRefresh", wdtRefresh, 1'b0);
    @(negedge clk); @(negedge clk);
    rstN = 1;
    repeat (5) cyc();
    // R2: pin low through end of reset -> entry, with halt exit (R7)
    sysRst = 0;
    cyc();
    check("R2 pin entry dbgMode", dbgMode, 1'b1);
    check("R7 haltExitReq on entry", haltExitReq, 1'b1);
    check("R5 fetch off in debug", fetchEn, 1'b0);
    haltMode = 0; dbgPinN = 1;
    cyc();
    check("R7 haltExitReq one cycle", haltExitReq, 1'b0);
    check("R2 stays in debug", dbgMode, 1'b1);
    // R6
    wdtEnable = 1; #1;
    check("R6 refresh in debug", wdtRefresh, 1'b1);
    wdtEnable = 0; #1;
    check("R6 no refresh when disabled", wdtRefresh, 1'b0);
    // R8
    stopMode = 1; #1;
    check("R8 stop gates peripherals", periphEn, 1'b0);
    stopMode = 0; #1;
    check("R8 debug does not gate peripherals", periphEn, 1'b1);
    // R10 execute one instruction
    @(negedge clk);
    execReq = 1;
    cyc(); execReq = 0;
    check("R10 fetch on after request", fetchEn, 1'b1);
    execReq = 1;
    cyc(); execReq = 0;
    check("R10 fetch held until done", fetchEn, 1'b1);
    instrDone = 1;
    cyc(); instrDone = 0;
    check("R10 fetch off after done", fetchEn, 1'b0);
    check("R10 still in debug", dbgMode, 1'b1);
    // R3 software clear
    ctlWrEn = 1; ctlWrData = 0;
    cyc(); idleInputs();
    check("R3 write 0 exits", dbgMode, 1'b0);
    check("R5 fetch on outside debug", fetchEn, 1'b1);
    // R9 write 1 has no effect
    ctlWrEn = 1; ctlWrData = 1;
    cyc(); idleInputs();
    check("R9 write 1 ignored", dbgMode, 1'b0);
    // R1 breakpoint, no halt
    brkStrobe = 1;
    cyc(); idleInputs();
    check("R1 breakpoint entry", dbgMode, 1'b1);
    check("R7 no halt exit when not halted", haltExitReq, 1'b0);
    check("R9 readback after entry", dbgMode, 1'b1);
    // R4 cause exit
    wdtStrobe = 1;
    cyc(); idleInputs();
    check("R4 watchdog exit", dbgMode, 1'b0);
    brkStrobe = 1; borStrobe = 1;
    cyc(); idleInputs();
    check("R4 brownout beats breakpoint", dbgMode, 1'b0);
    brkStrobe = 1; ctlWrEn = 1; ctlWrData = 0;
    cyc(); idleInputs();
    check("R3 clear beats breakpoint", dbgMode, 1'b0);
    brkStrobe = 1;
    cyc(); idleInputs();
    porStrobe = 1;
    cyc(); idleInputs();
    check("R4 power-on exit", dbgMode, 1'b0);
    // R2 pin high at end of reset -> no entry
    dbgPinN = 1; sysRst = 1;
    repeat (4) cyc();
    sysRst = 0;
    cyc();
    check("R2 pin high no entry", dbgMode, 1'b0);
    cyc();
    check("R2 pin high still out", dbgMode, 1'b0);

    // Random phase against the cycle model
    mQ = 0; exQ = 0; hxQ = 0;
    for (int i = 0; i < 3000; i++) begin
      porStrobe = ($urandom_range(0, 63) == 0);
      borStrobe = ($urandom_range(0, 63) == 0);
      wdtStrobe = ($urandom_range(0, 63) == 0);
      brkStrobe = ($urandom_range(0, 7) == 0);
      ctlWrEn   = ($urandom_range(0, 9) == 0);
      ctlWrData = 1'($urandom_range(0, 1));
      execReq   = ($urandom_range(0, 3) == 0);
      instrDone = ($urandom_range(0, 2) == 0);
      haltMode  = 1'($urandom_range(0, 1));
      wdtEnable = 1'($urandom_range(0, 1));
      stopMode  = ($urandom_range(0, 7) == 0);
      cause = porStrobe | borStrobe | wdtStrobe;
      clr   = ctlWrEn & ~ctlWrData;
      mN  = expMode(mQ, cause, clr, brkStrobe);
      exN = expExec(mQ, mN, exQ, execReq, instrDone);
      hxQ = !mQ && mN && haltMode;
      mQ = mN; exQ = exN;
      cyc();
      check("R1 R3 R4 random dbgMode", dbgMode, mQ);
      check("R5 R10 random fetchEn", fetchEn, !mQ || exQ);
      check("R7 random haltExitReq", haltExitReq, hxQ);
      check("R6 random wdtRefresh", wdtRefresh, mQ && wdtEnable);
      check("R8 random periphEn", periphEn, !stopMode);
    end
    idleInputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule